// File: doc/BRIEF.md
# Word/Byte ALU with Status Flags

This block computes arithmetic, logical and single-bit Boolean results and keeps a four-bit status word describing the most recent operation. Each cycle it takes an opcode, a width select, two data operands and two bit operands. The result appears combinationally on `result`. When `valid` is high, the status word (carry, overflow, zero, negative) is captured on the next rising clock edge.

Arithmetic operations are add, subtract, compare and negate. Subtract, compare and negate are formed as two's-complement additions, and the carry flag is reported as a borrow for them. The logical operations are AND, OR, XOR and one's complement. Either operand width may be used: in byte mode only the low byte takes part, and the carry and sign come from the top bit of that byte.

The bit operations take a destination bit `bit_a` (its value before the operation) and a source bit `bit_b`. For these operations the flags have a different meaning. One-operand bit operations report the previous destination bit on N. Two-operand bit operations report the AND of the two bits on C and their XOR on N.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 0 (ADD) gives result = (a + b) masked to the selected width. C is the carry out of the top bit of that width: bit 15 in word mode, bit 7 in byte mode.
- R2: Opcode 1 (SUB) gives result = a - b masked to the width. Opcode 2 (CMP) sets flags from a - b but outputs `op_a` masked to the width. For both, C = 1 exactly when unsigned a < b, which is a borrow.
- R3: For ADD, SUB, CMP and NEG, V = 1 exactly when the signed true result lies outside -8000h..+7FFFh (word) or -80h..+7Fh (byte).
- R4: For opcodes 0..7, N is the top bit of the width result and Z = 1 when the width-masked result is zero. In byte mode, `op_a`/`op_b` bits 15..8 are ignored and `result` bits 15..8 are zero.
- R5: Opcode 3 (NEG) gives result = 0 - a masked to the width, with C = 1 exactly when the masked a is nonzero.
- R6: Opcodes 4 AND, 5 OR, 6 XOR and 7 CPL (one's complement of a) clear C and V.
- R7: Opcodes 8 (BSET, result bit 1) and 9 (BCLR, result bit 0) clear C and V. They set N = `bit_a` and Z = inverse of the result bit. The result bit is placed on `result[0]` and the other result bits are zero.
- R8: Opcodes 10 BAND (a&b), 11 BOR (a|b), 12 BXOR (a^b) and 13 BMOV (b) put the result bit on `result[0]`. They set C = `bit_a & bit_b`, N = `bit_a ^ bit_b`, V = 0 and Z = inverse of the result bit.
- R9: Flags change only on the rising edge after a cycle with `valid` high. Reserved opcodes 14 and 15 leave the flags unchanged and drive `result` to zero.
- R10: A low `rst_n` at a rising edge clears all flags. The flags port is {N, Z, V, C}, bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Capture the flags of this cycle's operation |
| opcode | input | 4 | Operation code (see R1..R9) |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| op_a | input | 16 | First data operand |
| op_b | input | 16 | Second data operand |
| bit_a | input | 1 | Destination bit, value before the operation |
| bit_b | input | 1 | Source bit |
| result | output | 16 | Combinational result |
| flags | output | 4 | Registered {N, Z, V, C} |

## Verification
The bench builds the block with its default widths, a 16-bit word and an 8-bit byte. At these widths, the signed limits 7FFFh/8000h and 7Fh/80h can be reached directly with directed operands. Random operands with upper-byte noise in byte mode show that bits 15..8 never reach the result or the flags. Every bit-operation combination of the two bit inputs is driven, as are both reserved opcodes and cycles where `valid` is low.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
// Shared opcode encoding and status-word layout for the flag ALU.
// Assumes a 4-bit opcode space; codes 14 and 15 are reserved.
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_NEG  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CPL  = 4'd7,
        OP_BSET = 4'd8,
        OP_BCLR = 4'd9,
        OP_BAND = 4'd10,
        OP_BOR  = 4'd11,
        OP_BXOR = 4'd12,
        OP_BMOV = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    // Status word, bit 3 down to bit 0: N, Z, V, C.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;

    // Arithmetic unit sub-operations.
    typedef enum logic [1:0] {
        AR_ADD = 2'd0,
        AR_SUB = 2'd1,
        AR_NEG = 2'd2
    } arith_sel_e;

endpackage

// File: rtl/alu_arith.sv
`timescale 1ns/1ps
// Adder datapath for add, subtract/compare and negate.
// Subtraction is formed as lhs + ~rhs + 1. Word and byte sums are built in
// parallel and one is selected. Carry is returned as a borrow for subtract
// and negate. Assumes BYTE_W < WORD_W.
module alu_arith
    import alu_flag_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  arith_sel_e          sel,
    input  logic                byte_mode,
    input  logic [WORD_W-1:0]   a,
    input  logic [WORD_W-1:0]   b,
    output logic [WORD_W-1:0]   res,
    output logic                c_flag,
    output logic                v_flag
);
    localparam int HI_W = WORD_W - BYTE_W;

    logic [WORD_W-1:0] lhs;
    logic [WORD_W-1:0] rhs;
    logic              cin;
    logic [WORD_W:0]   sum_w;
    logic [BYTE_W:0]   sum_b;
    logic              carry;
    logic              s_lhs, s_rhs, s_res;

    // Pick adder inputs for the requested sub-operation.
    always_comb begin
        unique case (sel)
            AR_SUB:  begin lhs = a;  rhs = ~b; cin = 1'b1; end
            AR_NEG:  begin lhs = '0; rhs = ~a; cin = 1'b1; end
            default: begin lhs = a;  rhs = b;  cin = 1'b0; end
        endcase
    end

    // Full-width and low-byte sums, each with its own carry out.
    always_comb begin
        sum_w = {1'b0, lhs} + {1'b0, rhs} + {{WORD_W{1'b0}}, cin};
        sum_b = {1'b0, lhs[BYTE_W-1:0]} + {1'b0, rhs[BYTE_W-1:0]}
              + {{BYTE_W{1'b0}}, cin};
    end

    // Select width, derive borrow-style carry and signed overflow.
    always_comb begin
        if (byte_mode) begin
            res   = {{HI_W{1'b0}}, sum_b[BYTE_W-1:0]};
            carry = sum_b[BYTE_W];
            s_lhs = lhs[BYTE_W-1];
            s_rhs = rhs[BYTE_W-1];
            s_res = sum_b[BYTE_W-1];
        end else begin
            res   = sum_w[WORD_W-1:0];
            carry = sum_w[WORD_W];
            s_lhs = lhs[WORD_W-1];
            s_rhs = rhs[WORD_W-1];
            s_res = sum_w[WORD_W-1];
        end
        c_flag = (sel == AR_ADD) ? carry : ~carry;
        v_flag = (s_lhs == s_rhs) && (s_res != s_lhs);
    end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
// Bitwise AND/OR/XOR/complement with byte masking of the upper bits.
// Assumes BYTE_W < WORD_W.
module alu_logic #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [1:0]          sel,
    input  logic                byte_mode,
    input  logic [WORD_W-1:0]   a,
    input  logic [WORD_W-1:0]   b,
    output logic [WORD_W-1:0]   res
);
    genvar i;
    generate
        for (i = 0; i < WORD_W; i++) begin : g_bit
            logic raw;
            // Per-bit logic function selected by sel.
            always_comb begin
                unique case (sel)
                    2'd0:    raw = a[i] & b[i];
                    2'd1:    raw = a[i] | b[i];
                    2'd2:    raw = a[i] ^ b[i];
                    default: raw = ~a[i];
                endcase
            end
            if (i < BYTE_W) begin : g_low
                assign res[i] = raw;
            end else begin : g_high
                assign res[i] = raw & ~byte_mode;
            end
        end
    endgenerate

endmodule

// File: rtl/alu_bitop.sv
`timescale 1ns/1ps
// Single-bit Boolean operations and their redefined flags.
// bit_a is the destination bit before the operation, bit_b the source.
// sel 0..1 are one-operand ops, 2..5 two-operand ops.
module alu_bitop
    import alu_flag_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       bit_a,
    input  logic       bit_b,
    output logic       res_bit,
    output alu_flags_t flg
);
    logic one_opnd;

    // Result bit and flags for the addressed bit operation.
    always_comb begin
        one_opnd = (sel < 3'd2);
        unique case (sel)
            3'd0:    res_bit = 1'b1;
            3'd1:    res_bit = 1'b0;
            3'd2:    res_bit = bit_a & bit_b;
            3'd3:    res_bit = bit_a | bit_b;
            3'd4:    res_bit = bit_a ^ bit_b;
            default: res_bit = bit_b;
        endcase
        flg.v = 1'b0;
        flg.z = ~res_bit;
        flg.c = one_opnd ? 1'b0  : (bit_a & bit_b);
        flg.n = one_opnd ? bit_a : (bit_a ^ bit_b);
    end

endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
// Top: decodes the opcode, routes operands to the arithmetic, logic and
// bit-operation units, drives the combinational result and registers
// the {N,Z,V,C} status word on a valid strobe. Synchronous active-low reset.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [3:0]        opcode,
    input  logic              byte_mode,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              bit_a,
    input  logic              bit_b,
    output logic [WORD_W-1:0] result,
    output logic [3:0]        flags
);
    localparam int HI_W = WORD_W - BYTE_W;

    alu_op_e           op;
    arith_sel_e        ar_sel;
    logic [WORD_W-1:0] ar_res, lg_res, a_masked;
    logic              ar_c, ar_v;
    logic              bt_res;
    alu_flags_t        bt_flg;
    logic              is_arith, is_logic, is_bit, known;
    logic [2:0]        bt_sel;
    logic [WORD_W-1:0] flag_src;
    logic              src_msb;
    alu_flags_t        flags_d, flags_q;

    // Opcode class decode and sub-unit selects.
    always_comb begin
        op       = alu_op_e'(opcode);
        is_arith = (opcode[3:2] == 2'b00);
        is_logic = (opcode[3:2] == 2'b01);
        is_bit   = opcode[3] && (opcode < 4'd14);
        known    = is_arith || is_logic || is_bit;
        unique case (op)
            OP_ADD:  ar_sel = AR_ADD;
            OP_NEG:  ar_sel = AR_NEG;
            default: ar_sel = AR_SUB;
        endcase
        bt_sel   = opcode[2:0] - 3'd0;
        if (opcode[2]) bt_sel = {1'b1, opcode[1:0]};
        else           bt_sel = {1'b0, opcode[1:0]};
        a_masked = byte_mode ? {{HI_W{1'b0}}, op_a[BYTE_W-1:0]} : op_a;
    end

    alu_arith #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_arith (
        .sel       (ar_sel),
        .byte_mode (byte_mode),
        .a         (op_a),
        .b         (op_b),
        .res       (ar_res),
        .c_flag    (ar_c),
        .v_flag    (ar_v)
    );

    alu_logic #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_logic (
        .sel       (opcode[1:0]),
        .byte_mode (byte_mode),
        .a         (op_a),
        .b         (op_b),
        .res       (lg_res)
    );

    alu_bitop u_bitop (
        .sel     (bt_sel),
        .bit_a   (bit_a),
        .bit_b   (bit_b),
        .res_bit (bt_res),
        .flg     (bt_flg)
    );

    // Result mux; compare leaves the destination operand on the output.
    always_comb begin
        if (op == OP_CMP)   result = a_masked;
        else if (is_arith)  result = ar_res;
        else if (is_logic)  result = lg_res;
        else if (is_bit)    result = {{(WORD_W-1){1'b0}}, bt_res};
        else                result = '0;
    end

    // Next flags from the class of the current operation.
    always_comb begin
        flag_src = is_arith ? ar_res : lg_res;
        src_msb  = byte_mode ? flag_src[BYTE_W-1] : flag_src[WORD_W-1];
        if (is_bit) begin
            flags_d = bt_flg;
        end else begin
            flags_d.n = src_msb;
            flags_d.z = (flag_src == '0);
            flags_d.c = is_arith ? ar_c : 1'b0;
            flags_d.v = is_arith ? ar_v : 1'b0;
        end
    end

    // Status register: cleared by reset, loaded on a valid known opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)              flags_q <= '0;
        else if (valid && known) flags_q <= flags_d;
    end

    assign flags = flags_q;

    // R9: no strobe, no change.
    a_r9_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(flags));

    // R9: reserved codes leave the status word alone.
    a_r9_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode >= 4'd14) |=> $stable(flags));

    // R6: logical ops clear C and V.
    a_r6_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode[3:2] == 2'b01) |=> (flags[1:0] == 2'b00));

    // R7: one-operand bit ops report the previous bit on N, clear C.
    a_r7_prev_bit_on_n: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (opcode == 4'd8 || opcode == 4'd9))
        |=> (flags[3] == $past(bit_a)) && (flags[0] == 1'b0));

    // R8: two-operand bit ops: C = AND, N = XOR.
    a_r8_and_xor_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && opcode >= 4'd10 && opcode <= 4'd13)
        |=> (flags[0] == $past(bit_a & bit_b)) && (flags[3] == $past(bit_a ^ bit_b)));

    // R4: byte mode never drives the upper result bits.
    a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> (result[WORD_W-1:BYTE_W] == '0));

endmodule

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid;
    logic [3:0]  opcode;
    logic        byte_mode;
    logic [15:0] op_a, op_b;
    logic        bit_a, bit_b;
    logic [15:0] result;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] exp_fl;

    always #5 clk = ~clk;

    alu_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode),
        .byte_mode(byte_mode), .op_a(op_a), .op_b(op_b),
        .bit_a(bit_a), .bit_b(bit_b), .result(result), .flags(flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ovf(input int s, input int w);
        return (s > (1 << (w-1)) - 1 || s < -(1 << (w-1))) ? 1 : 0;
    endfunction

    // Reference model built from the requirements.
    function automatic void model(input logic [3:0] op, input logic bm,
                                  input logic [15:0] a, input logic [15:0] b,
                                  input logic ba, input logic bb,
                                  input logic [3:0] old,
                                  output logic [15:0] r, output logic [3:0] fl);
        int w = bm ? 8 : 16;
        int mask = (1 << w) - 1;
        int ua = int'(a) & mask;
        int ub = int'(b) & mask;
        int sa = (ua >= (1 << (w-1))) ? ua - (1 << w) : ua;
        int sb = (ub >= (1 << (w-1))) ? ub - (1 << w) : ub;
        int rr = 0;
        int c = 0, v = 0, n, z, rb;
        if (op <= 4'd7) begin
            case (op)
                4'd0: begin rr = (ua + ub) & mask; c = ((ua + ub) >> w) & 1; v = ovf(sa + sb, w); end
                4'd1, 4'd2: begin rr = (ua - ub) & mask; c = (ua < ub) ? 1 : 0; v = ovf(sa - sb, w); end
                4'd3: begin rr = (-ua) & mask; c = (ua != 0) ? 1 : 0; v = ovf(-sa, w); end
                4'd4: rr = ua & ub;
                4'd5: rr = ua | ub;
                4'd6: rr = ua ^ ub;
                default: rr = (~ua) & mask;
            endcase
            n = (rr >> (w-1)) & 1;
            z = (rr == 0) ? 1 : 0;
            if (op == 4'd2) rr = ua;
            r  = 16'(rr);
            fl = {n[0], z[0], v[0], c[0]};
        end else if (op <= 4'd13) begin
            case (op)
                4'd8:  rb = 1;
                4'd9:  rb = 0;
                4'd10: rb = int'(ba & bb);
                4'd11: rb = int'(ba | bb);
                4'd12: rb = int'(ba ^ bb);
                default: rb = int'(bb);
            endcase
            r = {15'b0, rb[0]};
            if (op <= 4'd9) fl = {ba, ~rb[0], 1'b0, 1'b0};
            else            fl = {ba ^ bb, ~rb[0], 1'b0, ba & bb};
        end else begin
            r  = '0;
            fl = old;
        end
    endfunction

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1, 4'd2: return "R2";
            4'd3: return "R5";
            4'd4, 4'd5, 4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            4'd10, 4'd11, 4'd12, 4'd13: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Apply one strobed operation; check result now and flags after the edge.
    task automatic run_op(input logic [3:0] op, input logic bm,
                          input logic [15:0] a, input logic [15:0] b,
                          input logic ba, input logic bb);
        logic [15:0] er;
        logic [3:0]  ef;
        @(negedge clk);
        opcode = op; byte_mode = bm; op_a = a; op_b = b; bit_a = ba; bit_b = bb; valid = 1'b1;
        #1;
        model(op, bm, a, b, ba, bb, exp_fl, er, ef);
        chk({tag(op), " result"}, {16'b0, result}, {16'b0, er});
        @(negedge clk);
        valid = 1'b0;
        exp_fl = ef;
        #1;
        chk({tag(op), " flags R3 R4"}, {28'b0, flags}, {28'b0, exp_fl});
    endtask

    initial begin
        rst_n = 1'b0; valid = 1'b0; opcode = '0; byte_mode = 1'b0;
        op_a = '0; op_b = '0; bit_a = 1'b0; bit_b = 1'b0; exp_fl = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R10 reset flags", {28'b0, flags}, 32'h0);
        rst_n = 1'b1;

        // R1 / R3 word corners.
        run_op(4'd0, 1'b0, 16'h7FFF, 16'h0001, 0, 0);  // V=1,N=1
        run_op(4'd0, 1'b0, 16'hFFFF, 16'h0001, 0, 0);  // C=1,Z=1
        // R1 / R4 byte with upper noise.
        run_op(4'd0, 1'b1, 16'hAB7F, 16'hCD01, 0, 0);  // V=1,N=1
        run_op(4'd0, 1'b1, 16'h12FF, 16'h3401, 0, 0);  // C=1,Z=1
        // R2 borrow, R3 overflow.
        run_op(4'd1, 1'b0, 16'h0000, 16'h0001, 0, 0);
        run_op(4'd1, 1'b0, 16'h8000, 16'h0001, 0, 0);
        run_op(4'd2, 1'b0, 16'h1234, 16'h1234, 0, 0);
        run_op(4'd2, 1'b1, 16'hFF80, 16'h0001, 0, 0);
        // R5 negate corners.
        run_op(4'd3, 1'b0, 16'h8000, 16'h0000, 0, 0);
        run_op(4'd3, 1'b0, 16'h0000, 16'h0000, 0, 0);
        run_op(4'd3, 1'b1, 16'h5580, 16'h0000, 0, 0);
        // R6 after a flag-setting add.
        run_op(4'd0, 1'b0, 16'h8000, 16'h8000, 0, 0);
        run_op(4'd7, 1'b0, 16'h0000, 16'h0000, 0, 0);
        run_op(4'd4, 1'b1, 16'hFF00, 16'h00FF, 0, 0);
        // R7 / R8 all bit combinations.
        for (int o = 8; o <= 13; o++)
            for (int k = 0; k < 4; k++)
                run_op(4'(o), 1'b0, 16'h0, 16'h0, k[1], k[0]);
        // R9 reserved codes and missing strobe.
        run_op(4'd0, 1'b0, 16'hFFFF, 16'h0001, 0, 0);
        run_op(4'd14, 1'b0, 16'h1111, 16'h2222, 1, 1);
        run_op(4'd15, 1'b1, 16'h3333, 16'h4444, 0, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            opcode = 4'($urandom); op_a = 16'($urandom); op_b = 16'($urandom);
            bit_a = 1'($urandom); bit_b = 1'($urandom); valid = 1'b0;
            @(negedge clk); #1;
            chk("R9 hold without valid", {28'b0, flags}, {28'b0, exp_fl});
        end
        // Random mix.
        for (int i = 0; i < 600; i++)
            run_op(4'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                   1'($urandom), 1'($urandom));
        // R10 reset mid-run.
        run_op(4'd1, 1'b0, 16'h0000, 16'h0001, 0, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 reset clears flags", {28'b0, flags}, 32'h0);
        rst_n = 1'b1; exp_fl = '0;
        run_op(4'd0, 1'b0, 16'h0001, 16'h0001, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule